// File: doc/BRIEF.md
# Signed Saturating Adder with Optional Operand Doubling

This block performs clamped two's-complement arithmetic on a pair of signed operands. It offers four operations: a plain add, a plain subtract, and versions of each in which the second operand is first doubled. When a sum or difference would fall outside the signed range, the block clamps the result to the largest or smallest representable value instead of letting it wrap. The doubling step clamps on its own as well, so one operation can clamp twice.

Each operation is presented for one cycle with a valid strobe. The registered result and a matching valid strobe come out one clock later. A sticky flag records that some operation has clamped since the flag was last cleared. Only a dedicated clear input resets the flag.

Top module: `sat_arith`

## Requirements
- R1: After reset, `res_vld` is 0, `res_data` is 0 and `sat_flag` is 0.
- R2: `res_vld` is high in the cycle after a cycle with `op_vld` high, and low in the cycle after a cycle with `op_vld` low. `res_data` holds its value while `op_vld` is low.
- R3: Opcode 0 (add) gives `src_a + src_b` when the sum stays in the signed range. Overflow means both inputs have the same sign and the result has the other sign.
- R4: Opcode 1 (subtract) gives `src_a - src_b` when the difference stays in the signed range. Overflow means the input signs differ and the result sign differs from that of `src_a`.
- R5: When an add or subtract overflows, the result is 0x7FFFFFFF if the wrapped sum has bit 31 set, and 0x80000000 otherwise.
- R6: Opcodes 2 (doubled add) and 3 (doubled subtract) first replace `src_b` with 2·`src_b`. If bits 31 and 30 of `src_b` differ, the doubled value clamps to 0x80000000 for a negative `src_b` and to 0x7FFFFFFF for a positive one. Otherwise it is `src_b` shifted left by one bit. The add or subtract of R3 to R5 then uses this doubled value.
- R7: A valid operation that clamps in either stage sets `sat_flag` in the same cycle that its result appears. An operation with no clamp leaves the flag unchanged.
- R8: `sat_flag` returns to 0 only in the cycle after a cycle with `sat_clr` high. A clamp in that same cycle still leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | Operation strobe |
| op_sel | input | 2 | 0 add, 1 sub, 2 doubled add, 3 doubled sub |
| src_a | input | WIDTH | First operand |
| src_b | input | WIDTH | Second operand (the one doubled) |
| sat_clr | input | 1 | Clears the sticky flag |
| res_vld | output | 1 | Result strobe, one cycle after `op_vld` |
| res_data | output | WIDTH | Clamped result |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The bench first builds the block with WIDTH=6. At that width every pair of operands under all four opcodes, 16384 cases, can be swept exhaustively against arithmetic done in wide integers. That sweep reaches every combination of doubling clamp, add or subtract clamp, and no clamp. A second instance with the default WIDTH=32 covers the named boundary values. These are maximum plus one, minimum minus one, doubling 0x40000000 and 0xBFFFFFFF (both clamp), and doubling 0xC0000000 (no clamp). The flag's clear-versus-set priority is also checked.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_DADD = 2'd2,
    OP_DSUB = 2'd3
  } sat_op_e;
endpackage

// File: rtl/sat_double.sv
module sat_double #(
  parameter int WIDTH = 32
) (
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             clamp
);
  localparam logic [WIDTH-1:0] MAXV = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};

  logic ovf;

  always_comb begin
    ovf = din[WIDTH-1] ^ din[WIDTH-2];
    if (!en) begin
      dout  = din;
      clamp = 1'b0;
    end else if (ovf) begin
      dout  = din[WIDTH-1] ? MINV : MAXV;
      clamp = 1'b1;
    end else begin
      dout  = {din[WIDTH-2:0], 1'b0};
      clamp = 1'b0;
    end
  end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int WIDTH = 32
) (
  input  logic             sub,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y,
  output logic             clamp
);
  localparam logic [WIDTH-1:0] MAXV = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] raw;
  logic             sa, sb, sr;

  always_comb begin
    raw = sub ? (a - b) : (a + b);
    sa  = a[WIDTH-1];
    sb  = b[WIDTH-1];
    sr  = raw[WIDTH-1];
    if (sub) clamp = (sa != sb) && (sr != sa);
    else     clamp = (sa == sb) && (sr != sa);
    if (clamp) y = sr ? MAXV : MINV;
    else       y = raw;
  end
endmodule

// File: rtl/sat_arith.sv
module sat_arith
  import sat_arith_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_vld,
  input  logic [1:0]       op_sel,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic             sat_clr,
  output logic             res_vld,
  output logic [WIDTH-1:0] res_data,
  output logic             sat_flag
);
  logic [WIDTH-1:0] dbl_val, sum_val;
  logic             dbl_clamp, sum_clamp;
  logic             vld_q, flag_q, vld_d, flag_d;
  logic [WIDTH-1:0] data_q, data_d;
  sat_op_e          op;

  assign op = sat_op_e'(op_sel);

  sat_double #(.WIDTH(WIDTH)) u_dbl (
    .en   (op == OP_DADD || op == OP_DSUB),
    .din  (src_b),
    .dout (dbl_val),
    .clamp(dbl_clamp)
  );

  sat_addsub #(.WIDTH(WIDTH)) u_as (
    .sub  (op == OP_SUB || op == OP_DSUB),
    .a    (src_a),
    .b    (dbl_val),
    .y    (sum_val),
    .clamp(sum_clamp)
  );

  always_comb begin
    vld_d  = op_vld;
    data_d = op_vld ? sum_val : data_q;
    flag_d = flag_q;
    if (sat_clr) flag_d = 1'b0;
    if (op_vld && (dbl_clamp || sum_clamp)) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
      flag_q <= flag_d;
    end
  end

  assign res_vld  = vld_q;
  assign res_data = data_q;
  assign sat_flag = flag_q;
endmodule

// File: rtl/sat_arith_chk.sv
module sat_arith_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_vld,
  input logic [1:0]       op_sel,
  input logic [WIDTH-1:0] src_a,
  input logic [WIDTH-1:0] src_b,
  input logic             sat_clr,
  input logic             res_vld,
  input logic [WIDTH-1:0] res_data,
  input logic             sat_flag
);
  localparam logic [WIDTH-1:0] MAXV = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |=> res_vld);

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |=> $stable(res_data));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !op_vld) |=> !sat_flag);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_sel == 2'd0 && src_a[WIDTH-1] != src_b[WIDTH-1])
      |=> res_data == $past(src_a + src_b));

  // R6
  dbl_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_sel == 2'd2 && src_a == '0 && src_b[WIDTH-1] != src_b[WIDTH-2])
      |=> (res_data == MAXV || res_data == MINV) && sat_flag);
endmodule

bind sat_arith sat_arith_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_sat_arith.sv
module sim_sat_arith;
  localparam int SW = 6;
  localparam int LW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          s_vld, s_clr, s_rv, s_fl;
  logic [1:0]    s_op;
  logic [SW-1:0] s_a, s_b, s_y;

  logic          l_vld, l_clr, l_rv, l_fl;
  logic [1:0]    l_op;
  logic [LW-1:0] l_a, l_b, l_y;

  int n_chk = 0;
  int n_err = 0;

  sat_arith #(.WIDTH(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_vld(s_vld), .op_sel(s_op),
    .src_a(s_a), .src_b(s_b), .sat_clr(s_clr),
    .res_vld(s_rv), .res_data(s_y), .sat_flag(s_fl));

  sat_arith #(.WIDTH(LW)) u1 (
    .clk(clk), .rst_n(rst_n), .op_vld(l_vld), .op_sel(l_op),
    .src_a(l_a), .src_b(l_b), .sat_clr(l_clr),
    .res_vld(l_rv), .res_data(l_y), .sat_flag(l_fl));

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic longint clampv(input longint v, input int w, output bit c);
    longint mx = (longint'(1) << (w - 1)) - 1;
    longint mn = -(longint'(1) << (w - 1));
    c = 1'b0;
    if (v > mx) begin c = 1'b1; return mx; end
    if (v < mn) begin c = 1'b1; return mn; end
    return v;
  endfunction

  function automatic longint sx(input longint v, input int w);
    longint m = (longint'(1) << w) - 1;
    longint u = v & m;
    if (u[w-1]) return u - (longint'(1) << w);
    return u;
  endfunction

  function automatic longint ref_op(input int op, input longint a, input longint b,
                                    input int w, output bit c);
    bit c1, c2;
    longint bb = b;
    longint r;
    c1 = 1'b0;
    if (op >= 2) bb = clampv(2 * b, w, c1);
    if (op == 1 || op == 3) r = clampv(a - bb, w, c2);
    else                    r = clampv(a + bb, w, c2);
    c = c1 | c2;
    return r;
  endfunction

  task automatic l_run(input string req, input int op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] exp_y, input bit exp_f);
    @(negedge clk);
    l_vld = 1'b1; l_op = 2'(op); l_a = a; l_b = b; l_clr = 1'b1;
    @(negedge clk);
    l_vld = 1'b0; l_clr = 1'b0;
    chk(req, longint'(l_y), longint'(exp_y));
    chk({req, " flag"}, longint'(l_fl), longint'(exp_f));
  endtask

  initial begin
    #50000000;
    n_chk++; n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    s_vld = 0; s_clr = 0; s_op = 0; s_a = 0; s_b = 0;
    l_vld = 0; l_clr = 0; l_op = 0; l_a = 0; l_b = 0;
    #12;
    // R1 reset values
    chk("R1 vld", longint'(s_rv), 0);
    chk("R1 data", longint'(l_y), 0);
    chk("R1 flag", longint'(l_fl), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Exhaustive sweep at small width: R3 R4 R5 R6 R7
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < (1 << SW); a++) begin
        for (int b = 0; b < (1 << SW); b++) begin
          bit c;
          longint e;
          @(negedge clk);
          s_vld = 1'b1; s_clr = 1'b1; s_op = 2'(op);
          s_a = SW'(a); s_b = SW'(b);
          e = ref_op(op, sx(a, SW), sx(b, SW), SW, c);
          @(negedge clk);
          s_vld = 1'b0; s_clr = 1'b0;
          chk("R3/R4/R5/R6 sweep", sx(longint'(s_y), SW), e);
          chk("R7 sweep flag", longint'(s_fl), longint'(c));
          chk("R2 vld", longint'(s_rv), 1);
        end
      end
    end
    @(negedge clk);
    chk("R2 idle vld", longint'(s_rv), 0);

    // Wide corner cases
    l_run("R5 max+1", 0, 32'h7FFFFFFF, 32'h1, 32'h7FFFFFFF, 1);
    l_run("R5 min-1", 1, 32'h80000000, 32'h1, 32'h80000000, 1);
    l_run("R6 dbl 40000000", 2, 32'h0, 32'h40000000, 32'h7FFFFFFF, 1);
    l_run("R6 dbl BFFFFFFF", 2, 32'h0, 32'hBFFFFFFF, 32'h80000000, 1);
    l_run("R6 dbl C0000000", 2, 32'h0, 32'hC0000000, 32'h80000000, 0);
    l_run("R6 dsub C0000000", 3, 32'h1, 32'hC0000000, 32'h7FFFFFFF, 1);
    l_run("R3 add", 0, 32'h12345678, 32'h11111111, 32'h23456789, 0);
    l_run("R4 sub", 1, 32'h5, 32'h7, 32'hFFFFFFFE, 0);

    // R7 stickiness: clamp then non-clamping op without clear
    @(negedge clk);
    l_vld = 1; l_op = 0; l_a = 32'h7FFFFFFF; l_b = 32'h7FFFFFFF; l_clr = 0;
    @(negedge clk);
    l_a = 32'h1; l_b = 32'h1;
    @(negedge clk);
    l_vld = 0;
    chk("R7 sticky data", longint'(l_y), 2);
    chk("R7 sticky flag", longint'(l_fl), 1);
    // R2 hold while idle
    @(negedge clk);
    chk("R2 hold", longint'(l_y), 2);
    // R8 clear alone
    l_clr = 1;
    @(negedge clk);
    l_clr = 0;
    chk("R8 cleared", longint'(l_fl), 0);
    // R8 clear plus clamp in the same cycle: set wins
    l_clr = 1; l_vld = 1; l_op = 1; l_a = 32'h80000000; l_b = 32'h1;
    @(negedge clk);
    l_clr = 0; l_vld = 0;
    chk("R8 set wins", longint'(l_fl), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule